// File: doc/BRIEF.md
# UART Power-Down Wake Controller

This block sits next to a UART receiver and brings the system out of power-down. Two sources can request a wake: an edge of a chosen direction on the clear-to-send modem input, and any change of level on the serial receive line. Each source has its own enable and its own sticky flag. The flags stay set until software clears them with a write-one strobe. The wake request is the OR of the flags whose enable is set.

Once a wake request appears, a recovery counter models the time the clock source needs to settle, and the run indication is raised only after that count has elapsed. A wake from the receive line also starts a start-bit compensation countdown, counted in UART clock cycles, from a value programmed before power-down. When the countdown ends, a one-cycle receiver-ready strobe tells the receiver it may now sample the start bit. For the first frame to survive, the compensation value has to stay below the baud divisor. A configuration-error output is high whenever it does not.

Top module: `uart_wake_ctrl`

## Requirements
- R1: With `pwr_down` and `data_wake_en` high, any change of level on `rx_pin` sets `data_wake_flag` and `wake_req`, visible 3 cycles after the pin changes (two synchroniser stages plus the flag register).
- R2: With `cts_act_lvl` = 0, a rising edge on `cts_pin` during power-down sets `cts_wake_flag` 3 cycles later, and a falling edge sets nothing.
- R3: With `cts_act_lvl` = 1, a falling edge on `cts_pin` during power-down sets `cts_wake_flag` 3 cycles later, and a rising edge sets nothing.
- R4: Pin edges that arrive while `pwr_down` is low, or while the source's enable is low, leave both flags at 0.
- R5: A flag stays set until its clear strobe is sampled high, and it reads 0 in the following cycle. When a new wake edge and the clear strobe arrive in the same cycle, the flag stays set.
- R6: `wake_req` is high exactly when at least one flag is set and that flag's enable is high. Changing an enable changes `wake_req` within the same cycle.
- R7: `cpu_run` rises STABLE_CYCLES+1 cycles after the first flag that raises `wake_req` is set. It falls one cycle after `wake_req` drops while `pwr_down` is high.
- R8: When `data_wake_flag` goes from 0 to 1, `rx_ready` pulses high for exactly one cycle, `comp_val`+1 cycles after the flag is set. A value of 0 gives the pulse in the very next cycle, and a value of 347 gives it 348 cycles after the flag.
- R9: `cfg_err` is high exactly when `baud_div` is less than or equal to `comp_val`.
- R10: After reset, every output is 0, provided both pins are held high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (UART clock domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | System is in power-down |
| cts_pin | input | 1 | Asynchronous clear-to-send pin |
| rx_pin | input | 1 | Asynchronous serial receive pin |
| cts_wake_en | input | 1 | Enable for the CTS wake source |
| data_wake_en | input | 1 | Enable for the receive-line wake source |
| cts_act_lvl | input | 1 | 0: rising CTS edge wakes; 1: falling CTS edge wakes |
| comp_val | input | COMP_W | Start-bit compensation count in clock cycles |
| baud_div | input | COMP_W | Baud divisor, checked against the compensation count |
| cts_flag_clr | input | 1 | Write-one strobe that clears the CTS flag |
| data_flag_clr | input | 1 | Write-one strobe that clears the data flag |
| wake_req | output | 1 | Wake request to the power controller |
| cts_wake_flag | output | 1 | Sticky CTS wake status |
| data_wake_flag | output | 1 | Sticky receive-line wake status |
| cpu_run | output | 1 | Clock recovered; processor may run |
| rx_ready | output | 1 | One-cycle strobe at the end of start-bit compensation |
| cfg_err | output | 1 | Compensation count not below baud divisor |

## Verification
Each result has a fixed latency after the stimulus that causes it. A flag is due 3 cycles after a pin change and 1 cycle after a clear strobe. The run indication is due STABLE_CYCLES+1 cycles after the flag, and the ready strobe comp_val+1 cycles after the flag. The enable masking and the configuration error are due in the same cycle. When the bench applies a stimulus, it queues each expected value under the cycle number in which that value is due. The monitor compares a queued item only in that cycle, half a period after the edge. For events that must not happen, it also checks the cycles just before and after the expected time.

// File: rtl/uart_wake_ctrl.sv
module uart_wake_ctrl #(
  parameter int COMP_W        = 16,
  parameter int STABLE_CYCLES = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              cts_pin,
  input  logic              rx_pin,
  input  logic              cts_wake_en,
  input  logic              data_wake_en,
  input  logic              cts_act_lvl,
  input  logic [COMP_W-1:0] comp_val,
  input  logic [COMP_W-1:0] baud_div,
  input  logic              cts_flag_clr,
  input  logic              data_flag_clr,
  output logic              wake_req,
  output logic              cts_wake_flag,
  output logic              data_wake_flag,
  output logic              cpu_run,
  output logic              rx_ready,
  output logic              cfg_err
);

  localparam int STB_W = $clog2(STABLE_CYCLES + 1);

  typedef enum logic [1:0] {ST_SLEEP, ST_RECOVER, ST_RUN} rec_state_t;

  logic [SYNC_STAGES:0] cts_sh, rx_sh;
  logic cts_now, cts_old, rx_now, rx_old;
  logic cts_hit, cts_set, data_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cts_sh <= '1;
      rx_sh  <= '1;
    end else begin
      cts_sh <= {cts_sh[SYNC_STAGES-1:0], cts_pin};
      rx_sh  <= {rx_sh[SYNC_STAGES-1:0], rx_pin};
    end

  assign cts_now = cts_sh[SYNC_STAGES-1];
  assign cts_old = cts_sh[SYNC_STAGES];
  assign rx_now  = rx_sh[SYNC_STAGES-1];
  assign rx_old  = rx_sh[SYNC_STAGES];

  assign cts_hit  = cts_act_lvl ? (cts_old & ~cts_now) : (cts_now & ~cts_old);
  assign cts_set  = pwr_down & cts_wake_en & cts_hit;
  assign data_set = pwr_down & data_wake_en & (rx_now ^ rx_old);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cts_wake_flag  <= 1'b0;
      data_wake_flag <= 1'b0;
    end else begin
      cts_wake_flag  <= cts_set  | (cts_wake_flag  & ~cts_flag_clr);
      data_wake_flag <= data_set | (data_wake_flag & ~data_flag_clr);
    end

  assign wake_req = (cts_wake_flag & cts_wake_en) | (data_wake_flag & data_wake_en);

  rec_state_t       rec_st;
  logic [STB_W-1:0] rec_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rec_st  <= ST_SLEEP;
      rec_cnt <= '0;
    end else begin
      case (rec_st)
        ST_SLEEP:
          if (wake_req) begin
            rec_st  <= ST_RECOVER;
            rec_cnt <= STB_W'(STABLE_CYCLES - 1);
          end
        ST_RECOVER:
          if (rec_cnt == '0) rec_st <= ST_RUN;
          else               rec_cnt <= rec_cnt - 1'b1;
        ST_RUN:
          if (pwr_down && !wake_req) rec_st <= ST_SLEEP;
        default: rec_st <= ST_SLEEP;
      endcase
    end

  assign cpu_run = (rec_st == ST_RUN);

  logic [COMP_W-1:0] comp_cnt;
  logic              comp_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      comp_cnt  <= '0;
      comp_busy <= 1'b0;
      rx_ready  <= 1'b0;
    end else begin
      rx_ready <= 1'b0;
      if (data_set && !data_wake_flag) begin
        comp_cnt  <= comp_val;
        comp_busy <= 1'b1;
      end else if (comp_busy) begin
        if (comp_cnt == '0) begin
          comp_busy <= 1'b0;
          rx_ready  <= 1'b1;
        end else begin
          comp_cnt <= comp_cnt - 1'b1;
        end
      end
    end

  assign cfg_err = (baud_div <= comp_val);

endmodule

module uart_wake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_down,
  input logic cts_flag_clr,
  input logic data_flag_clr,
  input logic cts_wake_flag,
  input logic data_wake_flag,
  input logic wake_req,
  input logic rx_ready
);

  p_cts_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_wake_flag && !cts_flag_clr) |=> cts_wake_flag);

  p_data_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wake_flag && !data_flag_clr) |=> data_wake_flag);

  p_cts_only_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_wake_flag) |-> $past(pwr_down));

  p_data_only_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_wake_flag) |-> $past(pwr_down));

  p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !rx_ready);

  p_no_flag_no_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_wake_flag && !data_wake_flag) |-> !wake_req);

endmodule

bind uart_wake_ctrl uart_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
  .cts_flag_clr(cts_flag_clr), .data_flag_clr(data_flag_clr),
  .cts_wake_flag(cts_wake_flag), .data_wake_flag(data_wake_flag),
  .wake_req(wake_req), .rx_ready(rx_ready)
);

// File: tb/sim_uart_wake_ctrl.sv
module sim_uart_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STB = 8;
  localparam int CW  = 16;

  localparam int S_WAKE = 0, S_CTS = 1, S_DATA = 2, S_RUN = 3, S_RDY = 4, S_ERR = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_down = 0, cts_pin = 1, rx_pin = 1, cts_wake_en = 0, data_wake_en = 0, cts_act_lvl = 0;
  logic [CW-1:0] comp_val = '0, baud_div = 16;
  logic cts_flag_clr = 0, data_flag_clr = 0;
  logic wake_req, cts_wake_flag, data_wake_flag, cpu_run, rx_ready, cfg_err;

  uart_wake_ctrl #(.COMP_W(CW), .STABLE_CYCLES(STB), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .cts_pin(cts_pin), .rx_pin(rx_pin),
    .cts_wake_en(cts_wake_en), .data_wake_en(data_wake_en), .cts_act_lvl(cts_act_lvl),
    .comp_val(comp_val), .baud_div(baud_div), .cts_flag_clr(cts_flag_clr),
    .data_flag_clr(data_flag_clr), .wake_req(wake_req), .cts_wake_flag(cts_wake_flag),
    .data_wake_flag(data_wake_flag), .cpu_run(cpu_run), .rx_ready(rx_ready), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int due; int sig; logic val; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic get_sig(int s);
    case (s)
      S_WAKE: return wake_req;
      S_CTS:  return cts_wake_flag;
      S_DATA: return data_wake_flag;
      S_RUN:  return cpu_run;
      S_RDY:  return rx_ready;
      default: return cfg_err;
    endcase
  endfunction

  task automatic expect_at(int sig, int dly, logic val, string req);
    exp_t e;
    e.due = cyc + dly; e.sig = sig; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        n_chk++;
        if (get_sig(q[i].sig) !== q[i].val) begin
          n_bad++;
          $display("FAIL %s: signal %0d at cycle %0d actual %b expected %b",
                   q[i].req, q[i].sig, cyc, get_sig(q[i].sig), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    // R10 reset state
    expect_at(S_WAKE, 1, 0, "R10"); expect_at(S_CTS, 1, 0, "R10");
    expect_at(S_DATA, 1, 0, "R10"); expect_at(S_RUN, 1, 0, "R10");
    expect_at(S_RDY, 1, 0, "R10");  expect_at(S_ERR, 1, 0, "R10");
    tick(3);

    // R2 rising edge wakes with polarity 0; falling does not
    pwr_down = 1; cts_wake_en = 1; tick(2);
    cts_pin = 0;
    expect_at(S_CTS, 3, 0, "R2"); expect_at(S_CTS, 5, 0, "R2"); expect_at(S_WAKE, 5, 0, "R2");
    tick(6);
    cts_pin = 1;
    expect_at(S_CTS, 2, 0, "R2"); expect_at(S_CTS, 3, 1, "R2"); expect_at(S_WAKE, 3, 1, "R6");
    expect_at(S_RUN, 3 + STB, 0, "R7"); expect_at(S_RUN, 4 + STB, 1, "R7");
    tick(14);
    cts_flag_clr = 1;
    expect_at(S_CTS, 1, 0, "R5"); expect_at(S_WAKE, 1, 0, "R6");
    expect_at(S_RUN, 1, 1, "R7"); expect_at(S_RUN, 2, 0, "R7");
    tick(1); cts_flag_clr = 0; tick(4);

    // R3 falling edge wakes with polarity 1; rising does not
    cts_act_lvl = 1; tick(1);
    cts_pin = 0;
    expect_at(S_CTS, 3, 1, "R3");
    tick(6);
    cts_flag_clr = 1; expect_at(S_CTS, 1, 0, "R5");
    tick(1); cts_flag_clr = 0; tick(3);
    cts_pin = 1;
    expect_at(S_CTS, 3, 0, "R3"); expect_at(S_CTS, 5, 0, "R3");
    tick(6);

    // R4 no wake outside power-down, none with enable low
    pwr_down = 0; tick(1);
    cts_pin = 0;
    expect_at(S_CTS, 3, 0, "R4"); expect_at(S_CTS, 5, 0, "R4"); expect_at(S_WAKE, 5, 0, "R4");
    tick(6);
    data_wake_en = 1; tick(1);
    rx_pin = 0;
    expect_at(S_DATA, 3, 0, "R4"); expect_at(S_DATA, 5, 0, "R4");
    tick(6); rx_pin = 1; tick(6);
    pwr_down = 1; data_wake_en = 0; tick(1);
    rx_pin = 0;
    expect_at(S_DATA, 3, 0, "R4"); expect_at(S_DATA, 5, 0, "R4"); expect_at(S_RDY, 4, 0, "R4");
    tick(6); rx_pin = 1; tick(6);

    // R1 / R8 data wake with compensation 5
    comp_val = 5; baud_div = 16; data_wake_en = 1; tick(1);
    rx_pin = 0;
    expect_at(S_DATA, 2, 0, "R1"); expect_at(S_DATA, 3, 1, "R1"); expect_at(S_WAKE, 3, 1, "R1");
    expect_at(S_RDY, 8, 0, "R8"); expect_at(S_RDY, 9, 1, "R8"); expect_at(S_RDY, 10, 0, "R8");
    expect_at(S_RUN, 4 + STB, 1, "R7");
    tick(14);

    // R6 enable masks the request
    data_wake_en = 0;
    expect_at(S_WAKE, 0, 0, "R6"); expect_at(S_DATA, 0, 1, "R6");
    tick(1);
    data_wake_en = 1; expect_at(S_WAKE, 0, 1, "R6");
    tick(1);

    // R5 a set arriving with the clear strobe wins
    rx_pin = 1;
    expect_at(S_DATA, 4, 1, "R5"); expect_at(S_RDY, 4, 0, "R8");
    tick(2); data_flag_clr = 1; tick(1); data_flag_clr = 0;
    tick(3);
    data_flag_clr = 1; expect_at(S_DATA, 1, 0, "R5");
    tick(1); data_flag_clr = 0; tick(3);

    // R8 compensation 0
    comp_val = 0;
    rx_pin = 0;
    expect_at(S_DATA, 3, 1, "R1"); expect_at(S_RDY, 3, 0, "R8");
    expect_at(S_RDY, 4, 1, "R8"); expect_at(S_RDY, 5, 0, "R8");
    tick(8);
    data_flag_clr = 1; tick(1); data_flag_clr = 0; tick(3);

    // R8 compensation 347 with baud divisor 400
    comp_val = 347; baud_div = 400;
    expect_at(S_ERR, 0, 0, "R9");
    rx_pin = 1;
    expect_at(S_DATA, 3, 1, "R1");
    expect_at(S_RDY, 350, 0, "R8"); expect_at(S_RDY, 351, 1, "R8"); expect_at(S_RDY, 352, 0, "R8");
    tick(360);

    // R9 configuration error boundary
    comp_val = 20; baud_div = 20; expect_at(S_ERR, 0, 1, "R9");
    tick(1);
    baud_div = 21; expect_at(S_ERR, 0, 0, "R9");
    tick(1);
    baud_div = 19; expect_at(S_ERR, 0, 1, "R9");
    tick(2);

    while (q.size() != 0) tick(1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule